// File: doc/BRIEF.md
# Chase Test-Vector Selection Sequencer

This block sits in front of a hard-decision Reed-Solomon decoder for a code with 255 symbols of 8 bits each, 239 of which carry information. Each received symbol arrives with its hard decision, a runner-up decision and a reliability metric. While the codeword streams in, the block keeps the three least reliable positions. Once the last symbol has been taken, it offers the downstream decoder a sequence of test vectors.

A test vector is described as three (position, replacement symbol, substitute-enable) triples, together with a 3-bit vector index. The decoder applies the triples to the hard-decision word, which it keeps itself. Vectors are issued lazily. The first is the plain hard-decision word. The next is offered only when the decoder reports that it failed on the current one. A reported success ends the codeword at once. If all eight vectors fail, the block flags a final failure. In either case it goes back to accepting a new codeword.

Top module: `chase_tv_seq`

## Requirements
- R1: During and right after reset, `tv_valid`, `final_fail` and `len_err` are 0 and `in_ready` is 1.
- R2: The three offered positions are the three lowest `in_rel` values of the codeword, where a lower value means less reliable. Slot 0 holds the least reliable position. Of equal metrics, the earlier position (the lower 0-based arrival index) takes the lower slot.
- R3: After the edge that accepts the 255th symbol, `tv_valid` is 0 at the next edge and rises at the second edge. The first vector has `tv_idx` = 0 and `tv_en` = 000.
- R4: Vectors follow binary counting order 0,1,…,7. `tv_en[i]` equals bit i of `tv_idx`. Slot i occupies bits [8i+7:8i] of `tv_pos` and `tv_sym`, and `tv_sym` slot i is the runner-up decision received at position `tv_pos` slot i.
- R5: While `tv_valid` is high and `tv_ack` is low, all vector outputs are held. The edge that sees `tv_ack` with `tv_valid` clears `tv_valid`.
- R6: `dec_fail` and `dec_ok` act only after a vector has been acknowledged. While a vector is still offered, or while the block is idle, they have no effect.
- R7: `dec_ok` on an acknowledged vector returns the block to idle. After that edge `in_ready` is 1 and `tv_valid` is 0.
- R8: `dec_fail` on vector 7 raises `final_fail` for exactly one cycle after that edge. The block is then idle (`in_ready` = 1) and offers no further vector.
- R9: A start marker that arrives after 1 to 254 symbols of a codeword raises `len_err` for one cycle. The partial codeword is discarded, and the marked beat becomes position 0 of a new codeword.
- R10: A beat accepted while idle without the start marker is discarded, raises `len_err` for one cycle and leaves `in_ready` high.
- R11: `in_ready` is 0 from the edge that accepts the 255th symbol until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Symbol beat present |
| in_ready | output | 1 | Block accepts symbol beats |
| in_sop | input | 1 | Beat is position 0 of a codeword |
| in_hard | input | 8 | Hard decision (passes unused; the decoder keeps the hard word) |
| in_second | input | 8 | Runner-up decision |
| in_rel | input | 6 | Reliability metric, lower is less reliable |
| tv_valid | output | 1 | Test vector offered |
| tv_ack | input | 1 | Decoder has taken the offered vector |
| tv_idx | output | 3 | Test-vector index |
| tv_pos | output | 24 | Three positions, slot i at bits [8i+7:8i] |
| tv_sym | output | 24 | Three replacement symbols, same slot layout |
| tv_en | output | 3 | Per-slot substitute enable |
| dec_fail | input | 1 | Decoder failed on the acknowledged vector |
| dec_ok | input | 1 | Decoder succeeded on the acknowledged vector |
| final_fail | output | 1 | One-cycle pulse: all vectors failed |
| len_err | output | 1 | One-cycle pulse: malformed codeword length |

## Verification
The bench builds the block with its defaults: three tracked positions and 255-symbol codewords. With these values all eight vectors can be walked through, up to the final-failure pulse, and a full-length frame completes without padding. The stimulus table plants low, tied and high metrics against a background pattern with its own ties. This exercises the tie rule, displacement of list entries and the case where the background itself supplies the minima. It also sets decoder success at vectors 0, 1, 3, 5 and 7, as well as never.

// File: rtl/chase_pkg.sv
package chase_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_SHOW,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/chase_frame_ctr.sv
module chase_frame_ctr #(
  parameter int N_SYM = 255,
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat,
  input  logic             sop,
  output logic [POS_W-1:0] pos,
  output logic             take,
  output logic             last,
  output logic             bad_len
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_SYM - 1);

  logic [POS_W-1:0] cnt_q;

  assign pos     = sop ? '0 : cnt_q;
  assign take    = beat && (sop || cnt_q != '0);
  assign last    = take && (pos == LAST_POS);
  assign bad_len = beat && (sop ? (cnt_q != '0) : (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= last ? '0 : pos + 1'b1;
    end
  end
endmodule

// File: rtl/chase_lrp_sort.sv
module chase_lrp_sort #(
  parameter int ETA   = 3,
  parameter int REL_W = 6,
  parameter int POS_W = 8,
  parameter int SYM_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        take,
  input  logic                        restart,
  input  logic [REL_W-1:0]            rel,
  input  logic [POS_W-1:0]            pos,
  input  logic [SYM_W-1:0]            sym,
  output logic [ETA-1:0][POS_W-1:0]   lst_pos,
  output logic [ETA-1:0][SYM_W-1:0]   lst_sym
);
  logic [ETA-1:0]             vld_a;
  logic [ETA-1:0][REL_W-1:0]  rel_a;
  logic [ETA-1:0]             cmp;

  for (genvar j = 0; j < ETA; j++) begin : g_ent
    logic             vld_q;
    logic [REL_W-1:0] rel_q;
    logic [POS_W-1:0] pos_q;
    logic [SYM_W-1:0] sym_q;
    logic             put_new;
    logic             shift_in;

    // strict compare: an equal metric lands behind the stored one
    assign cmp[j] = !vld_q || (rel < rel_q);

    if (j == 0) begin : g_head
      assign put_new  = cmp[0];
      assign shift_in = 1'b0;
    end else begin : g_tail
      assign put_new  = cmp[j] && !cmp[j-1];
      assign shift_in = cmp[j-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
      end else if (take) begin
        if (restart) begin
          vld_q <= (j == 0);
          rel_q <= rel;
          pos_q <= pos;
          sym_q <= sym;
        end else if (put_new) begin
          vld_q <= 1'b1;
          rel_q <= rel;
          pos_q <= pos;
          sym_q <= sym;
        end else if (shift_in) begin
          vld_q <= vld_a[(j > 0) ? j-1 : 0];
          rel_q <= rel_a[(j > 0) ? j-1 : 0];
          pos_q <= lst_pos[(j > 0) ? j-1 : 0];
          sym_q <= lst_sym[(j > 0) ? j-1 : 0];
        end
      end
    end

    assign vld_a[j]   = vld_q;
    assign rel_a[j]   = rel_q;
    assign lst_pos[j] = pos_q;
    assign lst_sym[j] = sym_q;
  end
endmodule

// File: rtl/chase_tv_gen.sv
module chase_tv_gen #(
  parameter int ETA   = 3,
  parameter int POS_W = 8,
  parameter int SYM_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      clr,
  input  logic [ETA-1:0]            nxt_idx,
  input  logic [ETA-1:0][POS_W-1:0] lst_pos,
  input  logic [ETA-1:0][SYM_W-1:0] lst_sym,
  output logic                      tv_valid,
  output logic [ETA-1:0]            tv_idx,
  output logic [ETA*POS_W-1:0]      tv_pos,
  output logic [ETA*SYM_W-1:0]      tv_sym,
  output logic [ETA-1:0]            tv_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tv_valid <= 1'b0;
      tv_idx   <= '0;
      tv_en    <= '0;
    end else if (load) begin
      tv_valid <= 1'b1;
      tv_idx   <= nxt_idx;
      tv_en    <= nxt_idx;
      tv_pos   <= lst_pos;
      tv_sym   <= lst_sym;
    end else if (clr) begin
      tv_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/chase_tv_seq.sv
module chase_tv_seq #(
  parameter int ETA   = 3,
  parameter int N_SYM = 255,
  parameter int SYM_W = 8,
  parameter int REL_W = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic                              in_sop,
  input  logic [SYM_W-1:0]                  in_hard,
  input  logic [SYM_W-1:0]                  in_second,
  input  logic [REL_W-1:0]                  in_rel,
  output logic                              tv_valid,
  input  logic                              tv_ack,
  output logic [ETA-1:0]                    tv_idx,
  output logic [ETA*$clog2(N_SYM)-1:0]      tv_pos,
  output logic [ETA*SYM_W-1:0]              tv_sym,
  output logic [ETA-1:0]                    tv_en,
  input  logic                              dec_fail,
  input  logic                              dec_ok,
  output logic                              final_fail,
  output logic                              len_err
);
  import chase_pkg::*;

  localparam int POS_W = $clog2(N_SYM);
  localparam logic [ETA-1:0] LAST_IDX = {ETA{1'b1}};

  seq_st_e                    st_q;
  logic                       beat, take, last, bad_len;
  logic [POS_W-1:0]           pos;
  logic [ETA-1:0][POS_W-1:0]  lst_pos;
  logic [ETA-1:0][SYM_W-1:0]  lst_sym;
  logic                       load, clr;
  logic [ETA-1:0]             nxt_idx;
  logic                       hard_unused;

  assign hard_unused = ^in_hard;
  assign in_ready    = (st_q == ST_IDLE);
  assign beat        = in_valid && in_ready;

  chase_frame_ctr #(.N_SYM(N_SYM), .POS_W(POS_W)) u_cnt (
    .clk(clk), .rst(rst), .beat(beat), .sop(in_sop),
    .pos(pos), .take(take), .last(last), .bad_len(bad_len)
  );

  chase_lrp_sort #(.ETA(ETA), .REL_W(REL_W), .POS_W(POS_W), .SYM_W(SYM_W)) u_sort (
    .clk(clk), .rst(rst), .take(take), .restart(in_sop),
    .rel(in_rel), .pos(pos), .sym(in_second),
    .lst_pos(lst_pos), .lst_sym(lst_sym)
  );

  always_comb begin
    load    = 1'b0;
    clr     = 1'b0;
    nxt_idx = '0;
    case (st_q)
      ST_ARM:  load = 1'b1;
      ST_SHOW: clr  = tv_ack;
      ST_WAIT: begin
        nxt_idx = tv_idx + 1'b1;
        load    = !dec_ok && dec_fail && (tv_idx != LAST_IDX);
      end
      default: ;
    endcase
  end

  chase_tv_gen #(.ETA(ETA), .POS_W(POS_W), .SYM_W(SYM_W)) u_gen (
    .clk(clk), .rst(rst), .load(load), .clr(clr), .nxt_idx(nxt_idx),
    .lst_pos(lst_pos), .lst_sym(lst_sym),
    .tv_valid(tv_valid), .tv_idx(tv_idx), .tv_pos(tv_pos),
    .tv_sym(tv_sym), .tv_en(tv_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      final_fail <= 1'b0;
      len_err    <= 1'b0;
    end else begin
      final_fail <= 1'b0;
      len_err    <= bad_len;
      case (st_q)
        ST_IDLE: if (last) st_q <= ST_ARM;
        ST_ARM:  st_q <= ST_SHOW;
        ST_SHOW: if (tv_ack) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (dec_ok) begin
            st_q <= ST_IDLE;
          end else if (dec_fail) begin
            if (tv_idx == LAST_IDX) begin
              final_fail <= 1'b1;
              st_q       <= ST_IDLE;
            end else begin
              st_q <= ST_SHOW;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chase_tv_seq_chk.sv
module chase_tv_seq_chk #(
  parameter int ETA   = 3,
  parameter int POS_W = 8,
  parameter int SYM_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 tv_valid,
  input logic                 tv_ack,
  input logic [ETA-1:0]       tv_idx,
  input logic [ETA*POS_W-1:0] tv_pos,
  input logic [ETA*SYM_W-1:0] tv_sym,
  input logic [ETA-1:0]       tv_en,
  input logic                 final_fail,
  input logic                 len_err
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < ETA; a++)
      for (int b = a + 1; b < ETA; b++)
        if (tv_pos[a*POS_W +: POS_W] == tv_pos[b*POS_W +: POS_W]) dup = 1'b1;
  end

  assert_distinct_R2: assert property (@(posedge clk) disable iff (rst)
    tv_valid |-> !dup);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    tv_valid && !tv_ack |=> tv_valid && $stable(tv_idx) && $stable(tv_pos)
                            && $stable(tv_sym) && $stable(tv_en));

  assert_ack_R5: assert property (@(posedge clk) disable iff (rst)
    tv_valid && tv_ack |=> !tv_valid);

  assert_order_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tv_valid) |-> (tv_idx == '0) || (tv_idx == ETA'($past(tv_idx) + 1'b1)));

  assert_final_R8: assert property (@(posedge clk) disable iff (rst)
    final_fail |-> !tv_valid && (&tv_idx) && in_ready);

  assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
    tv_valid |-> !in_ready);

  assert_pulses_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({final_fail, len_err}));
endmodule

bind chase_tv_seq chase_tv_seq_chk #(.ETA(ETA), .POS_W(POS_W), .SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .tv_valid(tv_valid),
  .tv_ack(tv_ack), .tv_idx(tv_idx), .tv_pos(tv_pos), .tv_sym(tv_sym),
  .tv_en(tv_en), .final_fail(final_fail), .len_err(len_err)
);

// File: tb/sim_chase_tv_seq.sv
module sim_chase_tv_seq;
  localparam int NS = 255;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_hard = '0, in_second = '0;
  logic [5:0]  in_rel = '0;
  logic        tv_ack = 1'b0, dec_fail = 1'b0, dec_ok = 1'b0;
  logic        in_ready, tv_valid, final_fail, len_err;
  logic [2:0]  tv_idx, tv_en;
  logic [23:0] tv_pos, tv_sym;

  int nchk = 0;
  int nbad = 0;
  int cyc  = 0;

  always #2.5 clk = ~clk;

  chase_tv_seq u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_hard(in_hard), .in_second(in_second), .in_rel(in_rel),
    .tv_valid(tv_valid), .tv_ack(tv_ack), .tv_idx(tv_idx), .tv_pos(tv_pos),
    .tv_sym(tv_sym), .tv_en(tv_en), .dec_fail(dec_fail), .dec_ok(dec_ok),
    .final_fail(final_fail), .len_err(len_err)
  );

  // entry: p0,p1,p2 (8b), r0,r1,r2 (6b), number of decoder failures (4b)
  localparam logic [45:0] TBL [6] = '{
    {8'd10,  8'd200, 8'd77,  6'd3,  6'd1,  6'd2,  4'd0},
    {8'd254, 8'd0,   8'd128, 6'd5,  6'd5,  6'd5,  4'd3},
    {8'd30,  8'd31,  8'd32,  6'd0,  6'd0,  6'd19, 4'd8},
    {8'd100, 8'd50,  8'd150, 6'd7,  6'd7,  6'd9,  4'd5},
    {8'd5,   8'd6,   8'd7,   6'd30, 6'd30, 6'd30, 4'd1},
    {8'd1,   8'd2,   8'd3,   6'd63, 6'd63, 6'd63, 4'd7}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++; nbad++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cyc);
      $display("%0d/%0d checks passed", nchk - nbad, nchk);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int rel_of(input logic [45:0] e, input int p);
    if (p == int'(e[45:38])) return int'(e[21:16]);
    if (p == int'(e[37:30])) return int'(e[15:10]);
    if (p == int'(e[29:22])) return int'(e[9:4]);
    return 20 + ((p * 7) % 40);
  endfunction

  function automatic int second_of(input int p);
    return (p + 51) & 255;
  endfunction

  task automatic expect_sel(input logic [45:0] e, output int sp [3]);
    bit used [NS];
    for (int p = 0; p < NS; p++) used[p] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      int best = -1;
      for (int p = 0; p < NS; p++)
        if (!used[p] && (best < 0 || rel_of(e, p) < rel_of(e, best))) best = p;
      used[best] = 1'b1;
      sp[k] = best;
    end
  endtask

  task automatic send_cw(input logic [45:0] e, input bit chk_le);
    for (int p = 0; p < NS; p++) begin
      @(negedge clk);
      if (p == 1 && chk_le) check("R9 len_err on early start marker", int'(len_err), 1);
      in_valid  = 1'b1;
      in_sop    = (p == 0);
      in_rel    = 6'(rel_of(e, p));
      in_hard   = 8'(p) ^ 8'h5A;
      in_second = 8'(second_of(p));
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    check("R11 in_ready low after last symbol", int'(in_ready), 0);
    check("R3 tv_valid low one edge after last symbol", int'(tv_valid), 0);
    @(negedge clk);
    check("R3 tv_valid high two edges after last symbol", int'(tv_valid), 1);
  endtask

  task automatic run_vectors(input logic [45:0] e, input bit probe);
    int sp [3];
    int nf = int'(e[3:0]);
    expect_sel(e, sp);
    for (int k = 0; k < 8; k++) begin
      check("R4 tv_valid for next vector", int'(tv_valid), 1);
      check("R4 tv_idx counting order", int'(tv_idx), k);
      check("R4 tv_en equals index bits", int'(tv_en), k);
      if (k == 0) check("R3 first vector has no substitutions", int'(tv_en), 0);
      for (int i = 0; i < 3; i++) begin
        check("R2 slot position", int'(tv_pos[i*8 +: 8]), sp[i]);
        check("R4 slot runner-up symbol", int'(tv_sym[i*8 +: 8]), second_of(sp[i]));
      end
      if (probe) begin
        @(negedge clk); dec_fail = 1'b1; dec_ok = 1'b1;
        @(negedge clk); dec_fail = 1'b0; dec_ok = 1'b0;
        check("R6 status ignored while offered", int'(tv_valid), 1);
        check("R5 index held until ack", int'(tv_idx), k);
      end
      @(negedge clk); tv_ack = 1'b1;
      @(negedge clk); tv_ack = 1'b0;
      check("R5 tv_valid cleared by ack", int'(tv_valid), 0);
      if (k < nf) dec_fail = 1'b1; else dec_ok = 1'b1;
      @(negedge clk); dec_fail = 1'b0; dec_ok = 1'b0;
      if (k >= nf) begin
        check("R7 idle after success", int'(in_ready), 1);
        check("R7 no vector after success", int'(tv_valid), 0);
        return;
      end
      if (k == 7) begin
        check("R8 final_fail after last failure", int'(final_fail), 1);
        check("R8 idle after final failure", int'(in_ready), 1);
        @(negedge clk);
        check("R8 final_fail lasts one cycle", int'(final_fail), 0);
        check("R8 no vector after final failure", int'(tv_valid), 0);
        return;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tv_valid in reset", int'(tv_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tv_valid after reset", int'(tv_valid), 0);
    check("R1 final_fail after reset", int'(final_fail), 0);
    check("R1 len_err after reset", int'(len_err), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    for (int t = 0; t < 6; t++) begin
      send_cw(TBL[t], 1'b0);
      run_vectors(TBL[t], t == 3);
    end

    // R9: abandoned partial codeword with very low metrics
    for (int p = 0; p < 10; p++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (p == 0); in_rel = 6'd0;
      in_second = 8'hEE; in_hard = 8'h00;
    end
    send_cw(TBL[0], 1'b1);
    run_vectors(TBL[0], 1'b0);

    // R10: stray beat while idle
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b0; in_rel = 6'd0; in_second = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 len_err on stray beat", int'(len_err), 1);
    check("R10 in_ready stays high", int'(in_ready), 1);
    @(negedge clk);
    check("R10 len_err one cycle", int'(len_err), 0);

    // R6: decoder status while idle
    dec_fail = 1'b1; dec_ok = 1'b1;
    @(negedge clk);
    dec_fail = 1'b0; dec_ok = 1'b0;
    @(negedge clk);
    check("R6 status ignored while idle: tv_valid", int'(tv_valid), 0);
    check("R6 status ignored while idle: final_fail", int'(final_fail), 0);
    check("R6 status ignored while idle: in_ready", int'(in_ready), 1);

    send_cw(TBL[3], 1'b0);
    run_vectors(TBL[3], 1'b0);

    $display("%0d/%0d checks passed", nchk - nbad, nchk);
    $finish;
  end
endmodule